// File: doc/BRIEF.md
# Balanced Two-Step Write Scheduler

This controller accepts row writes (a row address and a data word) through a valid/ready port and turns each one into two array steps for a memory whose cells are written through shared wordlines. The first step puts the row into an intermediate state. The second step brings it to the requested word. Both are computed from the requested word alone, because the stored row is never read. In every step each driven row receives exactly W/2 set pulses and W/2 clear pulses, whatever the data. The only data-dependent item an observer can see is the order of the two pulse phases in a step.

Consecutive writes are overlapped. In one command cycle the scheduler finishes the row that is waiting at its intermediate state and starts the next request on another row. A stream of N writes to distinct rows therefore uses N+1 command cycles. A row left waiting with no request behind it is finished alone after a programmable number of idle cycles. A request aimed at the waiting row first forces that row to finish.

A command carries two slots, a finishing slot and a starting slot. Each slot has its own valid, row, set mask and clear mask. The command also carries one phase-order bit that applies to both slots. When `cmd_ones_last` is 1, the clear phase is applied first and the set phase second. When it is 0, the set phase is applied first and the clear phase second. A bit that is in both masks of a slot ends with the value of the later phase. A bit in neither mask keeps its value.

Top module: `balanced_write_sched`

## Requirements
- R1: After a finishing-slot command for a row, the row holds exactly the requested word, whatever the row held before the write began.
- R2: Every valid slot of every command has exactly W/2 bits set in its set mask and exactly W/2 bits set in its clear mask.
- R3: When the finishing slot is valid, `cmd_ones_last` is 1 if the popcount of the finishing word is at least W/2, and 0 otherwise. When the finishing slot is idle, `cmd_ones_last` is 0.
- R4: When a row is waiting and the head request targets a different row, the finishing slot and the starting slot are issued in the same cycle to the two rows. N back-to-back writes to distinct rows occupy N+1 command cycles.
- R5: A request accepted at a clock edge while no request is queued appears in the starting slot on the command registered at the next clock edge.
- R6: With no queued request, a row whose starting step was issued in command cycle t is finished alone in cycle t + idle_limit + 1.
- R7: A head request to the waiting row produces a finishing-only command for that row. The new request starts in the following cycle.
- R8: `req_ready` is low while DEPTH requests are queued. A request presented while `req_ready` is low is not accepted and never reaches the array.
- R9: During reset both slots are idle, `cmd_ones_last` is 0 and `req_ready` is 1.
- R10: An idle slot drives a zero row, a zero set mask and a zero clear mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_limit | input | CW | Idle cycles a waiting row tolerates before being finished alone |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Request queue has room |
| req_row | input | AW | Target row of the request |
| req_data | input | W | Word to store |
| cmd_ones_last | output | 1 | Phase order: 1 = clear phase then set phase, 0 = set phase then clear phase |
| cmd_fin_v | output | 1 | Finishing slot valid |
| cmd_fin_row | output | AW | Row in its second step |
| cmd_fin_set | output | W | Bits pulsed to 1 in the finishing slot |
| cmd_fin_clr | output | W | Bits pulsed to 0 in the finishing slot |
| cmd_beg_v | output | 1 | Starting slot valid |
| cmd_beg_row | output | AW | Row in its first step |
| cmd_beg_set | output | W | Bits pulsed to 1 in the starting slot |
| cmd_beg_clr | output | W | Bits pulsed to 0 in the starting slot |

## Verification
The bench builds the block with W=8, AW=3, DEPTH=4 and CW=6. An 8-bit word makes it practical to stream all 256 data values through the pipeline, so every popcount class is covered, including the all-zero word, the all-one word and the exact-half words. Eight rows allow consecutive requests to land on distinct rows while the array model starts from non-zero contents. A four-entry queue fills within a few cycles once a same-row stream halves the drain rate, so back-pressure and the refused-request case are both exercised.

// File: rtl/balanced_write_sched.sv
module balanced_write_sched #(
  parameter int W     = 16,
  parameter int AW    = 6,
  parameter int DEPTH = 4,
  parameter int CW    = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] idle_limit,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_row,
  input  logic [W-1:0]  req_data,
  output logic          cmd_ones_last,
  output logic          cmd_fin_v,
  output logic [AW-1:0] cmd_fin_row,
  output logic [W-1:0]  cmd_fin_set,
  output logic [W-1:0]  cmd_fin_clr,
  output logic          cmd_beg_v,
  output logic [AW-1:0] cmd_beg_row,
  output logic [W-1:0]  cmd_beg_set,
  output logic [W-1:0]  cmd_beg_clr
);

  localparam int HALF = W / 2;
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW   = $clog2(DEPTH + 1);

  function automatic logic [W-1:0] first_n(input logic [W-1:0] src, input int n);
    logic [W-1:0] r;
    int c;
    r = '0;
    c = 0;
    for (int i = 0; i < W; i++)
      if (src[i] && c < n) begin
        r[i] = 1'b1;
        c++;
      end
    return r;
  endfunction

  function automatic logic majority(input logic [W-1:0] d);
    return $countones(d) >= HALF;
  endfunction

  // second step: majority value pulsed last on HALF majority bits,
  // minority bits pulsed first, padded with bits the last phase overrides
  function automatic logic [2*W-1:0] fin_plan(input logic [W-1:0] d);
    logic          v;
    logic [W-1:0]  dm, ndm, last, first;
    v     = majority(d);
    dm    = v ? d : ~d;
    ndm   = ~dm;
    last  = first_n(dm, HALF);
    first = ndm | first_n(last, HALF - $countones(ndm));
    return v ? {last, first} : {first, last};
  endfunction

  // first step: fix the majority bits the second step leaves untouched
  function automatic logic [2*W-1:0] beg_plan(input logic [W-1:0] d);
    logic          v;
    logic [W-1:0]  dm, rest, nrest, mv, mnv;
    v     = majority(d);
    dm    = v ? d : ~d;
    rest  = dm & ~first_n(dm, HALF);
    nrest = ~rest;
    mv    = rest | first_n(nrest, HALF - $countones(rest));
    mnv   = first_n(nrest, HALF);
    return v ? {mv, mnv} : {mnv, mv};
  endfunction

  logic [AW-1:0] q_row  [DEPTH];
  logic [W-1:0]  q_data [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] cnt;

  logic          hold_vld;
  logic [AW-1:0] hold_row;
  logic [W-1:0]  hold_data;
  logic [CW-1:0] idle_cnt;

  logic          has_head, conflict, idle_hit, do_fin, do_beg, push;
  logic [AW-1:0] head_row;
  logic [W-1:0]  head_data;
  logic [2*W-1:0] fin_p, beg_p;

  assign req_ready = cnt < NW'(DEPTH);
  assign push      = req_valid && req_ready;
  assign has_head  = cnt != '0;
  assign head_row  = q_row[rp];
  assign head_data = q_data[rp];
  assign conflict  = has_head && hold_vld && (head_row == hold_row);
  assign idle_hit  = !has_head && hold_vld && (idle_cnt >= idle_limit);
  assign do_fin    = hold_vld && (has_head || idle_hit);
  assign do_beg    = has_head && !conflict;
  assign fin_p     = fin_plan(hold_data);
  assign beg_p     = beg_plan(head_data);

  always_ff @(posedge clk)
    if (push) begin
      q_row[wp]  <= req_row;
      q_data[wp] <= req_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)   wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_beg) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + NW'(push) - NW'(do_beg);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_row  <= '0;
      hold_data <= '0;
      idle_cnt  <= '0;
    end else if (do_beg) begin
      hold_vld  <= 1'b1;
      hold_row  <= head_row;
      hold_data <= head_data;
      idle_cnt  <= '0;
    end else if (do_fin) begin
      hold_vld  <= 1'b0;
    end else if (hold_vld) begin
      idle_cnt  <= idle_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_ones_last <= 1'b0;
      cmd_fin_v     <= 1'b0;
      cmd_fin_row   <= '0;
      cmd_fin_set   <= '0;
      cmd_fin_clr   <= '0;
      cmd_beg_v     <= 1'b0;
      cmd_beg_row   <= '0;
      cmd_beg_set   <= '0;
      cmd_beg_clr   <= '0;
    end else begin
      cmd_ones_last <= do_fin && majority(hold_data);
      cmd_fin_v     <= do_fin;
      cmd_fin_row   <= do_fin ? hold_row : '0;
      {cmd_fin_set, cmd_fin_clr} <= do_fin ? fin_p : '0;
      cmd_beg_v     <= do_beg;
      cmd_beg_row   <= do_beg ? head_row : '0;
      {cmd_beg_set, cmd_beg_clr} <= do_beg ? beg_p : '0;
    end

  // R2
  fin_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fin_v |-> ($countones(cmd_fin_set) == HALF && $countones(cmd_fin_clr) == HALF));
  // R2
  beg_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_beg_v |-> ($countones(cmd_beg_set) == HALF && $countones(cmd_beg_clr) == HALF));
  // R4
  rows_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fin_v && cmd_beg_v) |-> (cmd_fin_row != cmd_beg_row));
  // R4
  beg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_beg_v |-> (hold_vld && hold_row == cmd_beg_row));
  // R7
  fin_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fin_v && !cmd_beg_v) |-> !hold_vld);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= NW'(DEPTH));
  // R10
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_fin_v |-> (cmd_fin_set == '0 && cmd_fin_clr == '0 && !cmd_ones_last));

endmodule

// File: tb/sim_balanced_write_sched.sv
`timescale 1ns/1ps
module sim_balanced_write_sched;
  localparam int W = 8, AW = 3, DEPTH = 4, CW = 6, HALF = W / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] idle_limit = 6'd50;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_row = '0;
  logic [W-1:0]  req_data = '0;
  logic          cmd_ones_last, cmd_fin_v, cmd_beg_v;
  logic [AW-1:0] cmd_fin_row, cmd_beg_row;
  logic [W-1:0]  cmd_fin_set, cmd_fin_clr, cmd_beg_set, cmd_beg_clr;

  always #2.5 clk = ~clk;

  balanced_write_sched #(.W(W), .AW(AW), .DEPTH(DEPTH), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row), .req_data(req_data),
    .cmd_ones_last(cmd_ones_last),
    .cmd_fin_v(cmd_fin_v), .cmd_fin_row(cmd_fin_row), .cmd_fin_set(cmd_fin_set), .cmd_fin_clr(cmd_fin_clr),
    .cmd_beg_v(cmd_beg_v), .cmd_beg_row(cmd_beg_row), .cmd_beg_set(cmd_beg_set), .cmd_beg_clr(cmd_beg_clr));

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_req = "R4";

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference of the schedule
  int qr[$], qd[$];
  bit m_hold;
  int m_row, m_data, m_idle;
  bit e_fv, e_bv;
  int e_frow, e_fdata, e_brow;
  int cyc = 0;

  always @(posedge clk) begin : model
    int  pre;
    bit  hh, conf;
    cyc++;
    if (!rst_n) begin
      qr.delete(); qd.delete();
      m_hold = 0; m_idle = 0; e_fv = 0; e_bv = 0;
    end else begin
      pre  = qr.size();
      hh   = pre > 0;
      conf = hh && m_hold && (qr[0] == m_row);
      e_fv = m_hold && (hh || m_idle >= int'(idle_limit));
      e_bv = hh && !conf;
      e_frow = m_row; e_fdata = m_data;
      e_brow = hh ? qr[0] : 0;
      if (e_bv) begin
        m_row = qr[0]; m_data = qd[0];
        void'(qr.pop_front()); void'(qd.pop_front());
        m_hold = 1; m_idle = 0;
      end else if (e_fv) m_hold = 0;
      else if (m_hold) m_idle++;
      if (req_valid && pre < DEPTH) begin
        qr.push_back(int'(req_row)); qd.push_back(int'(req_data));
      end
    end
  end

  logic [W-1:0] arr [0:(1<<AW)-1];
  int cmd_cycles = 0, last_beg_cyc = 0, last_fin_cyc = 0;
  bit saw_low = 0;

  function automatic logic [W-1:0] apply(input logic [W-1:0] cur, input logic [W-1:0] s,
                                         input logic [W-1:0] c, input logic ol);
    return ol ? ((cur & ~c) | s) : ((cur | s) & ~c);
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    chk(cmd_fin_v == e_fv, cur_req, "finish slot valid", cmd_fin_v, e_fv);
    chk(cmd_beg_v == e_bv, "R5", "start slot valid", cmd_beg_v, e_bv);
    chk(req_ready == (qr.size() < DEPTH), "R8", "ready", req_ready, qr.size() < DEPTH);
    if (!req_ready) saw_low = 1;
    if (cmd_fin_v || cmd_beg_v) cmd_cycles++;
    if (cmd_beg_v && e_bv) begin
      last_beg_cyc = cyc;
      chk(int'(cmd_beg_row) == e_brow, "R5", "start row", cmd_beg_row, e_brow);
      chk($countones(cmd_beg_set) == HALF && $countones(cmd_beg_clr) == HALF, "R2",
          "start slot pulse counts", {cmd_beg_set, cmd_beg_clr}, HALF);
      arr[cmd_beg_row] = apply(arr[cmd_beg_row], cmd_beg_set, cmd_beg_clr, cmd_ones_last);
    end else if (!cmd_beg_v) begin
      chk(cmd_beg_row == '0 && cmd_beg_set == '0 && cmd_beg_clr == '0, "R10",
          "idle start slot", {cmd_beg_row, cmd_beg_set, cmd_beg_clr}, 0);
    end
    if (cmd_fin_v && e_fv) begin
      last_fin_cyc = cyc;
      chk(int'(cmd_fin_row) == e_frow, cur_req, "finish row", cmd_fin_row, e_frow);
      chk(cmd_ones_last == ($countones(e_fdata[W-1:0]) >= HALF), "R3", "phase order",
          cmd_ones_last, $countones(e_fdata[W-1:0]) >= HALF);
      chk($countones(cmd_fin_set) == HALF && $countones(cmd_fin_clr) == HALF, "R2",
          "finish slot pulse counts", {cmd_fin_set, cmd_fin_clr}, HALF);
      arr[cmd_fin_row] = apply(arr[cmd_fin_row], cmd_fin_set, cmd_fin_clr, cmd_ones_last);
      chk(int'(arr[cmd_fin_row]) == e_fdata, "R1", "retired row contents", arr[cmd_fin_row], e_fdata);
    end else if (!cmd_fin_v) begin
      chk(!cmd_ones_last, "R3", "order with idle finish slot", cmd_ones_last, 0);
      chk(cmd_fin_row == '0 && cmd_fin_set == '0 && cmd_fin_clr == '0, "R10",
          "idle finish slot", {cmd_fin_row, cmd_fin_set, cmd_fin_clr}, 0);
    end
  end

  task automatic send(input int row, input int data);
    bit acc;
    req_valid = 1'b1;
    req_row   = AW'(row);
    req_data  = W'(data);
    do begin
      acc = req_ready;
      @(negedge clk);
    end while (!acc);
  endtask

  task automatic drop();
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [W-1:0] keep6;
    for (int i = 0; i < (1 << AW); i++) arr[i] = W'(i * 91 + 45);
    repeat (3) @(negedge clk);
    // R9
    chk(!cmd_fin_v && !cmd_beg_v, "R9", "slots during reset", {cmd_fin_v, cmd_beg_v}, 0);
    chk(!cmd_ones_last, "R9", "order during reset", cmd_ones_last, 0);
    chk(req_ready, "R9", "ready during reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: every word, rows changing each request
    cur_req = "R4";
    cmd_cycles = 0;
    for (int d = 0; d < 256; d++) send(d % 8, d);
    drop();
    repeat (70) @(negedge clk);
    chk(cmd_cycles == 257, "R4", "command cycles for 256 writes", cmd_cycles, 257);

    // R6: idle flush timing
    cur_req = "R6";
    idle_limit = 6'd3;
    send(1, 8'h3C); drop();
    repeat (10) @(negedge clk);
    chk(last_fin_cyc - last_beg_cyc == 4, "R6", "flush delay limit 3", last_fin_cyc - last_beg_cyc, 4);
    chk(arr[1] == 8'h3C, "R6", "flushed row", arr[1], 8'h3C);
    idle_limit = 6'd0;
    send(4, 8'hFF); drop();
    repeat (5) @(negedge clk);
    chk(last_fin_cyc - last_beg_cyc == 1, "R6", "flush delay limit 0", last_fin_cyc - last_beg_cyc, 1);

    // R7: same row twice in a row
    cur_req = "R7";
    idle_limit = 6'd20;
    cmd_cycles = 0;
    send(2, 8'hF1); send(2, 8'h0E); send(3, 8'h77); drop();
    repeat (30) @(negedge clk);
    chk(cmd_cycles == 5, "R7", "command cycles with same-row pair", cmd_cycles, 5);
    chk(arr[2] == 8'h0E, "R7", "row after rewrite", arr[2], 8'h0E);

    // R8: back-pressure and a refused request
    cur_req = "R8";
    idle_limit = 6'd5;
    keep6 = arr[6];
    for (int k = 0; k < 12; k++) send(5, k * 17);
    for (int t = 0; t < 20; t++) begin
      if (!req_ready) begin
        req_valid = 1'b1; req_row = 3'd6; req_data = 8'hA5;
        @(negedge clk);
        break;
      end
      drop();
      @(negedge clk);
    end
    drop();
    repeat (40) @(negedge clk);
    chk(saw_low, "R8", "ready dropped with full queue", saw_low, 1);
    chk(arr[6] == keep6, "R8", "refused request left row untouched", arr[6], keep6);
    chk(arr[5] == W'(11 * 17), "R1", "last same-row word", arr[5], W'(11 * 17));
    report();
  end
endmodule